// File: doc/BRIEF.md
# Barrel Shifter with Shift-Amount Register

This block is the shift stage that follows the ALU of a microcoded datapath. It takes a word from the ALU and returns a word for the destination registers. It also owns the shift-amount register (SAR) that controls how far the word moves. The stage has four modes: pass the word through, shift it right, shift it left by the complement of the amount, or rotate it right. The rotate is built as the XOR of a right shift and a left shift. The two shifts never set the same bit, so the XOR is the rotate.

Two control words from the current microcode step choose the mode. Each word gives one bit. The SAR changes only on a clock edge, from one of three sources:
- a literal packed into a microinstruction;
- its own complement;
- a folded copy of the shifter output from the current cycle.

When no source is selected, the SAR holds its value. The shifter output itself is combinational.

Top module: `rsu_top`

## Requirements
- R1: While rst_ni is low and after it is released, sar_o is 0.
- R2: Mode 0 drives result_o equal to data_i.
- R3: Mode 1 drives data_i shifted right logically by sar_o, filling with zeros.
- R4: Mode 2 drives data_i shifted left by (32 - sar_o). When sar_o is 0 the shift is by 32, so the result is 0.
- R5: Mode 3 drives the XOR of the mode 2 and mode 1 results, which is data_i rotated right by sar_o. When sar_o is 0 the result equals data_i.
- R6: The mode is a 2-bit value. Its high bit is nw_a_i[0] and its low bit is nw_b_i[15]. No other bit of either word affects result_o.
- R7: When sar_op_i is 0 or 3 and lit_load_i is low, sar_o does not change at the clock edge.
- R8: When sar_op_i is 1 and lit_load_i is low, the next sar_o is (32 - sar_o) mod 32. Complementing 0 therefore gives 0.
- R9: When sar_op_i is 2 and lit_load_i is low, the next sar_o is the low five bits of ((result_o >> 1) with its low two bits cleared) XOR (result_o & 3). This equals {result_o[5:3], result_o[1:0]}, taken from the result of the same cycle.
- R10: When lit_load_i is high, the next sar_o is (ucode_i[13:11] << 2) XOR ucode_i[9:8], which is {ucode_i[13:11], ucode_i[9:8]}. The literal load takes priority over sar_op_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 32 | Word from the ALU |
| nw_a_i | input | 16 | First control word; bit 0 is the high mode bit |
| nw_b_i | input | 16 | Second control word; bit 15 is the low mode bit |
| sar_op_i | input | 2 | SAR update: 0 hold, 1 complement, 2 load from output, 3 hold |
| lit_load_i | input | 1 | Load SAR from the microinstruction literal |
| ucode_i | input | 16 | Microinstruction carrying the SAR literal |
| result_o | output | 32 | Shifter output |
| sar_o | output | 5 | Current shift amount |

## Verification
Every shift amount from 0 to 31 is loaded through the literal path. Each mode is then checked on random and directed words.

A zero amount is the sharpest case. An implementation that forms 32 - SAR in five bits would shift left by 0 and return the input in mode 2 instead of zero. It would also double the word in the rotate, where the two halves should be disjoint.

The complement of 0 must stay 0. The fold for the output-sourced load must pick bits 5..3 and 1..0, so a plain truncation of the output gives a wrong amount the next cycle. The literal loaded together with a complement request must win. A swapped mode-bit pairing shows up as modes 1 and 2 trading places.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFTC = 2'd2,
    SH_ROTR  = 2'd3
  } sh_mode_e;

  typedef enum logic [1:0] {
    SAR_HOLD = 2'd0,
    SAR_CPL  = 2'd1,
    SAR_OUT  = 2'd2,
    SAR_IDLE = 2'd3
  } sar_op_e;
endpackage

// File: rtl/rsu_shift_core.sv
module rsu_shift_core
  import rsu_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  sh_mode_e      mode_i,
  output logic [W-1:0]  res_o
);
  // left amount is W - amt, i.e. two's negation in SW bits; amt==0 means a full-width shift
  logic [SW-1:0] lamt;
  logic          lzero;
  assign lamt  = '0 - amt_i;
  assign lzero = (amt_i == '0);

  logic [W-1:0] r_stg [SW+1];
  logic [W-1:0] l_stg [SW+1];
  assign r_stg[0] = data_i;
  assign l_stg[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign r_stg[k+1] = amt_i[k] ? (r_stg[k] >> (1 << k)) : r_stg[k];
    assign l_stg[k+1] = lamt[k]  ? (l_stg[k] << (1 << k)) : l_stg[k];
  end

  logic [W-1:0] right_w, left_w;
  assign right_w = r_stg[SW];
  assign left_w  = lzero ? '0 : l_stg[SW];

  always_comb begin
    unique case (mode_i)
      SH_PASS:  res_o = data_i;
      SH_RIGHT: res_o = right_w;
      SH_LEFTC: res_o = left_w;
      SH_ROTR:  res_o = left_w ^ right_w;
      default:  res_o = data_i;
    endcase
  end
endmodule

// File: rtl/rsu_sar_reg.sv
module rsu_sar_reg
  import rsu_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned UW   = 16,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sar_op_e       op_i,
  input  logic          lit_load_i,
  input  logic [UW-1:0] ucode_i,
  input  logic [W-1:0]  res_i,
  output logic [SW-1:0] sar_o
);
  logic [SW-1:0] sar_q, sar_d;
  logic [4:0]    lit5;
  logic [SW-1:0] lit_val;
  logic [W-1:0]  folded;

  assign lit5    = {ucode_i[13:11], 2'b00} ^ {3'b000, ucode_i[9:8]};
  assign lit_val = SW'(lit5);
  assign folded  = ({1'b0, res_i[W-1:1]} & ~W'(3)) ^ (res_i & W'(3));

  always_comb begin
    sar_d = sar_q;
    if (lit_load_i) begin
      sar_d = lit_val;
    end else begin
      unique case (op_i)
        SAR_CPL: sar_d = '0 - sar_q;
        SAR_OUT: sar_d = folded[SW-1:0];
        default: sar_d = sar_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sar_q <= '0;
    else         sar_q <= sar_d;
  end

  assign sar_o = sar_q;

  assert_rst_zero_R1: assert property (@(posedge clk_i) !rst_ni |=> sar_o == '0);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lit_load_i && (op_i == SAR_HOLD || op_i == SAR_IDLE)) |=> $stable(sar_o));
  assert_cpl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lit_load_i && op_i == SAR_CPL) |=> (sar_o + $past(sar_o)) == '0);
  assert_from_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lit_load_i && op_i == SAR_OUT) |=> sar_o == SW'({$past(res_i[5:3]), $past(res_i[1:0])}));
  assert_lit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit_load_i |=> sar_o == SW'({$past(ucode_i[13:11]), $past(ucode_i[9:8])}));
endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned NW  = 16,
  parameter int unsigned UW  = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  data_i,
  input  logic [NW-1:0] nw_a_i,
  input  logic [NW-1:0] nw_b_i,
  input  logic [1:0]    sar_op_i,
  input  logic          lit_load_i,
  input  logic [UW-1:0] ucode_i,
  output logic [W-1:0]  result_o,
  output logic [SW-1:0] sar_o
);
  sh_mode_e      mode;
  logic [SW-1:0] sar;

  // high mode bit from the first word's last bit, low bit from the second word's first bit
  assign mode = sh_mode_e'({nw_a_i[0], nw_b_i[NW-1]});

  rsu_shift_core #(.W(W)) u_core (
    .data_i (data_i),
    .amt_i  (sar),
    .mode_i (mode),
    .res_o  (result_o)
  );

  rsu_sar_reg #(.W(W), .UW(UW)) u_sar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (sar_op_e'(sar_op_i)),
    .lit_load_i (lit_load_i),
    .ucode_i    (ucode_i),
    .res_i      (result_o),
    .sar_o      (sar)
  );

  assign sar_o = sar;

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nw_a_i[0] && !nw_b_i[NW-1]) |-> result_o == data_i);
  assert_left_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nw_a_i[0] && !nw_b_i[NW-1] && sar_o == '0) |-> result_o == '0);
  assert_rot_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nw_a_i[0] && nw_b_i[NW-1] && sar_o == '0) |-> result_o == data_i);
  assert_rot_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nw_a_i[0] && nw_b_i[NW-1]) |-> $countones(result_o) == $countones(data_i));
endmodule

// File: tb/rsu_top_tb_top.sv
`timescale 1ns/1ps
module rsu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data = '0;
  logic [15:0] nwa = '0, nwb = '0, uc = '0;
  logic [1:0]  sop = '0;
  logic        lit = 1'b0;
  logic [31:0] res;
  logic [4:0]  sar;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rsu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .nw_a_i(nwa), .nw_b_i(nwb),
    .sar_op_i(sop), .lit_load_i(lit), .ucode_i(uc), .result_o(res), .sar_o(sar)
  );

  function automatic logic [31:0] ref_shift(input logic [1:0] m, input logic [31:0] d, input int s);
    logic [31:0] r, l;
    r = d >> s;
    l = (s == 0) ? 32'd0 : (d << (32 - s));
    case (m)
      2'd0: return d;
      2'd1: return r;
      2'd2: return l;
      default: return l ^ r;
    endcase
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_mode(input logic [1:0] m);
    nwa = 16'($urandom);
    nwb = 16'($urandom);
    nwa[0]  = m[1];
    nwb[15] = m[0];
  endtask

  // literal load: {uc[13:11], uc[9:8]} = v
  task automatic load_sar(input logic [4:0] v);
    @(negedge clk);
    uc = 16'($urandom);
    uc[13:11] = v[4:2];
    uc[9:8]   = v[1:0];
    lit = 1'b1;
    sop = 2'd0;
    @(negedge clk);
    lit = 1'b0;
    #1;
  endtask

  initial begin
    void'($urandom(32'd5177));
    #1;
    chk32("R1", 32'(sar), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk32("R1", 32'(sar), 32'd0);

    // R3 R4 R5 R2 R6: every amount, every mode
    for (int v = 0; v < 32; v++) begin
      load_sar(5'(v));
      chk32("R10", 32'(sar), 32'(v));
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 4; k++) begin
          drive_mode(2'(m));
          case (k)
            0: data = 32'hFFFF_FFFF;
            1: data = 32'h8000_0001;
            default: data = $urandom;
          endcase
          #1;
          case (m)
            0: chk32("R2/R6", res, ref_shift(2'(m), data, v));
            1: chk32("R3/R6", res, ref_shift(2'(m), data, v));
            2: chk32("R4/R6", res, ref_shift(2'(m), data, v));
            default: chk32("R5/R6", res, ref_shift(2'(m), data, v));
          endcase
        end
      end
    end

    // R8 complement, including 0
    for (int i = 0; i < 6; i++) begin
      automatic logic [4:0] v = (i == 0) ? 5'd0 : (i == 1) ? 5'd16 : 5'($urandom);
      load_sar(v);
      sop = 2'd1;
      @(negedge clk); sop = 2'd0; #1;
      chk32("R8", 32'(sar), 32'(5'(6'd32 - 6'(v))));
    end

    // R7 hold with op 0 and 3
    load_sar(5'd13);
    for (int i = 0; i < 4; i++) begin
      sop = (i % 2 == 0) ? 2'd0 : 2'd3;
      drive_mode(2'($urandom));
      data = $urandom;
      @(negedge clk); #1;
      chk32("R7", 32'(sar), 32'd13);
    end
    sop = 2'd0;

    // R9 load from same-cycle output
    for (int i = 0; i < 8; i++) begin
      automatic logic [4:0] v = 5'($urandom);
      automatic logic [1:0] m = 2'($urandom);
      automatic logic [31:0] o;
      load_sar(v);
      drive_mode(m);
      data = $urandom;
      o = ref_shift(m, data, int'(v));
      sop = 2'd2;
      @(negedge clk); sop = 2'd0; #1;
      chk32("R9", 32'(sar), 32'({o[5:3], o[1:0]}));
    end

    // R10 literal wins over complement
    load_sar(5'd7);
    @(negedge clk);
    uc = 16'h0000; uc[13:11] = 3'b101; uc[9:8] = 2'b10;
    lit = 1'b1; sop = 2'd1;
    @(negedge clk); lit = 1'b0; sop = 2'd0; #1;
    chk32("R10", 32'(sar), 32'b10110);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule